// File: doc/BRIEF.md
# Condition-Code ALU with Immediates

This block is the arithmetic and logic stage of a small 32-bit load-store datapath. Each cycle it combines a first register operand with a second operand, which is either a second register value or a 13-bit signed constant from the instruction word. An operation code picks one of six functions: bitwise AND, OR or NOR, a logical right shift, a 32-bit add, or an upper-constant load that places a 22-bit constant at the top of the word.

The result is purely combinational. Alongside it, four condition flags (negative, zero, overflow, carry) are derived from the same result. They are captured in a 4-bit status register at the rising clock edge, but only when the set-flags input is high and the operation is one that writes flags. Decode, the register file and branch evaluation sit outside and read the stored flags.

Top module: `cc_alu`

## Requirements
- R1: With op_sel 0, 1 or 2 the result is the bitwise AND, OR or NOR of operand A and operand B.
- R2: When use_imm is 1, operand B is imm13 sign-extended to 32 bits; when 0, operand B is rs2_val.
- R3: With op_sel 3 the result is operand A shifted right by the value in bits 4:0 of operand B, with zeros entering from the top.
- R4: With op_sel 5 the result is imm22 in bits 31:10 and zero in bits 9:0, and the status register keeps its value even when set_cc is 1.
- R5: With op_sel 4 the result is A + B modulo 2^32, and the carry flag is the carry out of bit 31.
- R6: For op_sel 4 the overflow flag is 1 exactly when A and B share a sign bit and the sum's sign bit differs from it.
- R7: For op_sel 0 to 4 the zero flag is 1 when the result is all zeros and the negative flag equals result bit 31; for op_sel 0 to 3 the carry and overflow flags are 0.
- R8: cc_reg = {n, z, v, c} in bits 3..0 takes the flags of the current operation at a rising edge only when set_cc is 1; otherwise it holds.
- R9: A synchronous active-high rst clears cc_reg to 0000 at the next rising edge, taking priority over set_cc.
- R10: op_sel 6 and 7 give a zero result and leave cc_reg unchanged even when set_cc is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the status register |
| op_sel | input | 3 | Operation code |
| use_imm | input | 1 | Select sign-extended imm13 as operand B |
| rs1_val | input | 32 | Operand A |
| rs2_val | input | 32 | Register value for operand B |
| imm13 | input | 13 | Signed instruction constant |
| imm22 | input | 22 | Upper constant for op_sel 5 |
| set_cc | input | 1 | Flag-write enable |
| result | output | 32 | Combinational result |
| cc_reg | output | 4 | Stored flags {n, z, v, c} |

## Verification
The assertions assume op_sel, set_cc and the operands are steady across each rising edge, so that the flags taken by the register match the result seen in the same cycle. They also assume rst is a clean level sampled at the edge. The bench changes all inputs only at the falling edge and picks op_sel over all eight codes, including the two unused ones. Random operands are mixed with directed values at the sign and carry boundaries.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_OR  = 3'd1,
        OP_NOR = 3'd2,
        OP_SRL = 3'd3,
        OP_ADD = 3'd4,
        OP_HI  = 3'd5,
        OP_RS6 = 3'd6,
        OP_RS7 = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_flags_t;

    function automatic logic op_writes_cc(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_NOR) ||
               (op == OP_SRL) || (op == OP_ADD);
    endfunction

    function automatic logic op_is_bitwise(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_NOR) ||
               (op == OP_SRL);
    endfunction

endpackage

// File: rtl/cc_operand_sel.sv
module cc_operand_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 13
) (
    input  logic              use_imm,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};

    always_comb begin
        opnd_b = use_imm ? imm_ext : reg_b;
    end
endmodule

// File: rtl/cc_logic_unit.sv
module cc_logic_unit
    import cc_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int SHAMT_W = $clog2(DATA_W);

    logic [SHAMT_W-1:0] shamt;

    assign shamt = b[SHAMT_W-1:0];

    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_NOR:  y = ~(a | b);
            OP_SRL:  y = a >> shamt;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/cc_adder.sv
module cc_adder #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide;

    always_comb begin
        wide  = {1'b0, a} + {1'b0, b};
        sum   = wide[MSB:0];
        carry = wide[DATA_W];
        ovf   = (a[MSB] == b[MSB]) && (wide[MSB] != a[MSB]);
    end
endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
    import cc_alu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  cc_flags_t d,
    output cc_flags_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/cc_alu.sv
module cc_alu
    import cc_alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 13,
    parameter int UPPER_W = 22
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         op_sel,
    input  logic               use_imm,
    input  logic [DATA_W-1:0]  rs1_val,
    input  logic [DATA_W-1:0]  rs2_val,
    input  logic [IMM_W-1:0]   imm13,
    input  logic [UPPER_W-1:0] imm22,
    input  logic               set_cc,
    output logic [DATA_W-1:0]  result,
    output logic [3:0]         cc_reg
);
    localparam int LOW_W = DATA_W - UPPER_W;
    localparam int MSB   = DATA_W - 1;

    alu_op_e           op;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] logic_y;
    logic [DATA_W-1:0] add_y;
    logic              add_c;
    logic              add_v;
    cc_flags_t         next_cc;
    cc_flags_t         cur_cc;
    logic              cc_wr;

    assign op = alu_op_e'(op_sel);

    cc_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
        .use_imm (use_imm),
        .reg_b   (rs2_val),
        .imm     (imm13),
        .opnd_b  (opnd_b)
    );

    cc_logic_unit #(.DATA_W(DATA_W)) u_logic (
        .op (op),
        .a  (rs1_val),
        .b  (opnd_b),
        .y  (logic_y)
    );

    cc_adder #(.DATA_W(DATA_W)) u_add (
        .a     (rs1_val),
        .b     (opnd_b),
        .sum   (add_y),
        .carry (add_c),
        .ovf   (add_v)
    );

    always_comb begin
        unique case (op)
            OP_ADD:  result = add_y;
            OP_HI:   result = {imm22, {LOW_W{1'b0}}};
            OP_RS6,
            OP_RS7:  result = '0;
            default: result = logic_y;
        endcase
    end

    always_comb begin
        next_cc.z = (result == '0);
        next_cc.n = result[MSB];
        next_cc.c = (op == OP_ADD) ? add_c : 1'b0;
        next_cc.v = (op == OP_ADD) ? add_v : 1'b0;
        cc_wr     = set_cc && op_writes_cc(op);
    end

    cc_flag_reg u_ccr (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cc_wr),
        .d     (next_cc),
        .q     (cur_cc)
    );

    assign cc_reg = cur_cc;
endmodule

// File: rtl/cc_alu_checker.sv
module cc_alu_checker #(
    parameter int DATA_W  = 32,
    parameter int UPPER_W = 22
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        op_sel,
    input logic              set_cc,
    input logic [DATA_W-1:0] result,
    input logic [3:0]        cc_reg
);
    localparam int LOW_W = DATA_W - UPPER_W;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cc_reg == 4'b0000)); // R9

    AST_HOLD_WITHOUT_SET: assert property (@(posedge clk) disable iff (rst)
        !set_cc |=> $stable(cc_reg)); // R8

    AST_UPPER_KEEPS_CC: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd5) |=> $stable(cc_reg)); // R4

    AST_UPPER_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd5) |-> (result[LOW_W-1:0] == '0)); // R4

    AST_SPARE_CODES: assert property (@(posedge clk) disable iff (rst)
        (op_sel[2:1] == 2'b11) |-> (result == '0)); // R10

    AST_SPARE_KEEP_CC: assert property (@(posedge clk) disable iff (rst)
        (op_sel[2:1] == 2'b11) |=> $stable(cc_reg)); // R10

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (set_cc && op_sel <= 3'd4) |=> (cc_reg[2] == ($past(result) == '0))); // R7

    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
        (set_cc && op_sel <= 3'd4) |=> (cc_reg[3] == $past(result[DATA_W-1]))); // R7

    AST_BITWISE_CLEARS_CV: assert property (@(posedge clk) disable iff (rst)
        (set_cc && op_sel <= 3'd3) |=> (cc_reg[1:0] == 2'b00)); // R7
endmodule

bind cc_alu cc_alu_checker #(.DATA_W(DATA_W), .UPPER_W(UPPER_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .op_sel (op_sel),
    .set_cc (set_cc),
    .result (result),
    .cc_reg (cc_reg)
);

// File: tb/sim_cc_alu.sv
module sim_cc_alu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_sel = 3'd0;
    logic        use_imm = 1'b0;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic [12:0] imm13 = '0;
    logic [21:0] imm22 = '0;
    logic        set_cc = 1'b0;
    logic [31:0] result;
    logic [3:0]  cc_reg;

    int checks = 0;
    int bad = 0;
    logic [3:0] exp_cc = 4'b0000;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cc_alu u0 (
        .clk(clk), .rst(rst), .op_sel(op_sel), .use_imm(use_imm),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .imm13(imm13), .imm22(imm22),
        .set_cc(set_cc), .result(result), .cc_reg(cc_reg)
    );

    function automatic logic [31:0] model_b(logic ui, logic [31:0] r2, logic [12:0] im);
        return ui ? {{19{im[12]}}, im} : r2;
    endfunction

    function automatic logic [31:0] model_res(logic [2:0] op, logic [31:0] a,
                                              logic [31:0] b, logic [21:0] hi);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b};
        case (op)
            3'd0: return a & b;
            3'd1: return a | b;
            3'd2: return ~(a | b);
            3'd3: return a >> b[4:0];
            3'd4: return s[31:0];
            3'd5: return {hi, 10'd0};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [3:0] model_cc(logic [2:0] op, logic [31:0] a,
                                            logic [31:0] b, logic [31:0] r);
        logic [32:0] s;
        logic c, v;
        s = {1'b0, a} + {1'b0, b};
        c = (op == 3'd4) ? s[32] : 1'b0;
        v = (op == 3'd4) ? ((a[31] == b[31]) && (r[31] != a[31])) : 1'b0;
        return {r[31], (r == 32'd0), v, c};
    endfunction

    function automatic string res_tag(logic [2:0] op, logic ui);
        if (ui) return "R2";
        case (op)
            3'd3: return "R3";
            3'd4: return "R5";
            3'd5: return "R4";
            3'd6, 3'd7: return "R10";
            default: return "R1";
        endcase
    endfunction

    function automatic string cc_tag(logic [2:0] op, logic sc);
        if (!sc) return "R8";
        case (op)
            3'd4: return "R6";
            3'd5: return "R4";
            3'd6, 3'd7: return "R10";
            default: return "R7";
        endcase
    endfunction

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s result act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check4(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cc_reg act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic apply(logic [2:0] op, logic ui, logic [31:0] a, logic [31:0] r2,
                         logic [12:0] im, logic [21:0] hi, logic sc);
        logic [31:0] b, r;
        @(negedge clk);
        op_sel = op; use_imm = ui; rs1_val = a; rs2_val = r2;
        imm13 = im; imm22 = hi; set_cc = sc;
        b = model_b(ui, r2, im);
        r = model_res(op, a, b, hi);
        #1;
        check32(res_tag(op, ui), result, r);
        if (sc && op <= 3'd4) exp_cc = model_cc(op, a, b, r);
        @(posedge clk);
        #1;
        check4(cc_tag(op, sc), cc_reg, exp_cc);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        bad++;
        $display("FAIL R8 watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check4("R9", cc_reg, 4'b0000);
        rst = 1'b0;

        // R1 bitwise ops
        apply(3'd0, 1'b0, 32'hF0F0_1234, 32'hFF00_FF00, 13'd0, 22'd0, 1'b1);
        apply(3'd1, 1'b0, 32'h0000_0000, 32'h0000_0000, 13'd0, 22'd0, 1'b1);
        apply(3'd2, 1'b0, 32'h0000_0000, 32'h0000_0000, 13'd0, 22'd0, 1'b1);
        // R2 immediate sign extension, negative and positive
        apply(3'd1, 1'b1, 32'h0000_0000, 32'hDEAD_BEEF, 13'h1000, 22'd0, 1'b1);
        apply(3'd0, 1'b1, 32'hFFFF_FFFF, 32'h0, 13'h0FFF, 22'd0, 1'b1);
        // R3 shift uses low five bits only
        apply(3'd3, 1'b0, 32'h8000_0000, 32'h0000_0021, 13'd0, 22'd0, 1'b1);
        apply(3'd3, 1'b0, 32'h8000_0000, 32'h0000_001F, 13'd0, 22'd0, 1'b1);
        // R5 carry out, R6 overflow cases
        apply(3'd4, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 13'd0, 22'd0, 1'b1);
        apply(3'd4, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 13'd0, 22'd0, 1'b1);
        apply(3'd4, 1'b0, 32'h8000_0000, 32'h8000_0000, 13'd0, 22'd0, 1'b1);
        apply(3'd4, 1'b1, 32'h0000_0005, 32'h0, 13'h1FFB, 22'd0, 1'b1);
        // R4 upper constant leaves flags alone
        apply(3'd5, 1'b0, 32'h1234_5678, 32'h0, 13'd0, 22'h3F_FFFF, 1'b1);
        // R10 spare codes
        apply(3'd6, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 13'd0, 22'h1, 1'b1);
        apply(3'd7, 1'b0, 32'h8000_0000, 32'h8000_0000, 13'd0, 22'h1, 1'b1);
        // R8 no update without set_cc
        apply(3'd4, 1'b0, 32'h0, 32'h0, 13'd0, 22'd0, 1'b0);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, r2;
            a  = $urandom();
            r2 = $urandom();
            if (($urandom() % 5) == 0) a = {a[31], 31'h7FFF_FFFF};
            apply(3'($urandom()), 1'($urandom()), a, r2, 13'($urandom()),
                  22'($urandom()), (($urandom() % 4) != 0));
        end

        // R9 reset beats set_cc
        apply(3'd4, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 13'd0, 22'd0, 1'b1);
        @(negedge clk);
        rst = 1'b1; set_cc = 1'b1; op_sel = 3'd4;
        rs1_val = 32'h8000_0000; rs2_val = 32'h8000_0000;
        @(posedge clk);
        #1;
        exp_cc = 4'b0000;
        check4("R9", cc_reg, exp_cc);
        @(negedge clk);
        rst = 1'b0; set_cc = 1'b0;
        @(posedge clk);
        #1;
        check4("R9", cc_reg, exp_cc);

        finish_run();
    end
endmodule